// File: doc/BRIEF.md
# Cluster Cache Coherence Miss Classifier

This block holds the coherence state of every line of a cluster cache and decides, for each processor access, whether it hits or which kind of miss it is. Lines are INVALID, SHARED or EXCLUSIVE. A read that finds no valid copy is a READ miss. A write that finds no copy is a WRITE miss. A write that finds a SHARED copy is an UPGRADE miss, which asks only for ownership. Every miss takes an entry in a small table of outstanding requests, indexed by line address. The entry number travels to the directory as a tag, and the directory returns it with the fill.

Only reads stall the processor. Writes and upgrades are posted, and the processor keeps issuing. A read to a line that still has an outstanding fill does not send a second request. It is classed as a merge and waits on the existing entry. Invalidations from remote clusters act at once, even on a line whose fill has not yet returned. In that case the fill still releases any waiting reader, but the line stays INVALID.

The controller has two states. RUN accepts accesses. WAIT_FILL holds the processor after a READ miss or a merge. The transition RUN→WAIT_FILL is taken on an accepted blocking read. The transition WAIT_FILL→RUN is taken when the fill carrying the awaited tag arrives.

Top module: `coh_miss_classifier`

## Requirements
- R1: After reset every line is INVALID, no request is outstanding, `req_ready` is 1, and `rsp_valid` and `rd_release` are 0.
- R2: A read to an INVALID line with no outstanding entry gives `rsp_kind`=1 (READ miss) one cycle after acceptance, together with a directory request of kind 0 for that line. `req_ready` then stays 0 until the matching fill, after which the line is SHARED.
- R3: A write to an INVALID line with no outstanding entry gives `rsp_kind`=2 (WRITE miss) and a directory request of kind 1, without lowering `req_ready`. After its fill the line is EXCLUSIVE.
- R4: A write to a SHARED line gives `rsp_kind`=3 (UPGRADE miss) and a directory request of kind 2, without lowering `req_ready`. After its fill the line is EXCLUSIVE.
- R5: A read to a SHARED or EXCLUSIVE line, and a write to an EXCLUSIVE line, give `rsp_kind`=0 (hit) and no directory request.
- R6: A read to a line that has an outstanding READ or WRITE entry gives `rsp_kind`=4 (merge) and no directory request, and the processor stalls. `rd_release` pulses for one cycle in the cycle after the awaited fill, and `req_ready` returns to 1 in that same cycle.
- R7: An invalidation makes its line INVALID from the next cycle on. If the line had an outstanding fill, that fill still releases any waiting reader but leaves the line INVALID.
- R8: At most ENTRY_N misses are outstanding. While every entry is in use, `req_ready` is 0. The `dir_req_tag` of each request names its entry, and `fill_tag` frees that entry.
- R9: A write to a line with an outstanding entry is held off (`req_ready`=0) until that fill returns. Accesses to other lines are not held off.
- R10: No access is accepted in a cycle in which `fill_valid` is 1.
- R11: A read to a line with an outstanding UPGRADE is a hit while the line is still SHARED. It is a merge once an invalidation has made the line INVALID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor access present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | LINE_W | Line address of the access |
| req_ready | output | 1 | Access is accepted this cycle when req_valid is also 1 |
| rsp_valid | output | 1 | Classification valid, one cycle after acceptance |
| rsp_kind | output | 3 | 0 hit, 1 READ, 2 WRITE, 3 UPGRADE, 4 merge |
| rd_release | output | 1 | One-cycle pulse: the stalled read's data has arrived |
| dir_req_valid | output | 1 | Request to the directory |
| dir_req_kind | output | 2 | 0 read shared, 1 write exclusive, 2 upgrade |
| dir_req_line | output | LINE_W | Line of the directory request |
| dir_req_tag | output | TAG_W | Outstanding entry used by the request |
| fill_valid | input | 1 | A fill or ownership grant returns |
| fill_tag | input | TAG_W | Entry the fill completes |
| inv_valid | input | 1 | Invalidation from a remote cluster |
| inv_line | input | LINE_W | Line to invalidate |

## Verification
The assertions assume that the directory only returns fills for tags it has been given, and returns each tag at most once. The bench keeps to this by taking every tag from the `dir_req_tag` output of the accepted request and sending one fill per request. Invalidations are free to arrive at any time, and the bench places them both on idle lines and on lines with a fill in flight. Since the processor port only presents one access at a time, stalled reads are released through the bench's own fill calls, never by further accesses.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    typedef enum logic [1:0] {
        LS_INVALID = 2'd0,
        LS_SHARED  = 2'd1,
        LS_EXCL    = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        AK_HIT     = 3'd0,
        AK_READ    = 3'd1,
        AK_WRITE   = 3'd2,
        AK_UPGRADE = 3'd3,
        AK_MERGE   = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        DR_READ    = 2'd0,
        DR_WRITE   = 2'd1,
        DR_UPGRADE = 2'd2
    } dir_kind_e;

    typedef enum logic {
        FS_RUN,
        FS_WAIT_FILL
    } ctl_st_e;

endpackage

// File: rtl/cmc_line_states.sv
module cmc_line_states
    import cmc_pkg::*;
#(
    parameter int LINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output line_st_e          rd_state,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  dir_kind_e         fill_kind,
    input  logic              fill_killed,
    input  logic              inv_en,
    input  logic [LINE_W-1:0] inv_line
);
    localparam int LINES = 1 << LINE_W;

    line_st_e st_q [LINES];

    assign rd_state = st_q[rd_line];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i] <= LS_INVALID;
            end
        end else begin
            if (fill_en) begin
                if (fill_killed) begin
                    st_q[fill_line] <= LS_INVALID;
                end else if (fill_kind == DR_READ) begin
                    st_q[fill_line] <= LS_SHARED;
                end else begin
                    st_q[fill_line] <= LS_EXCL;
                end
            end
            // invalidation applied last so it wins over a same-cycle fill
            if (inv_en) begin
                st_q[inv_line] <= LS_INVALID;
            end
        end
    end

    AST_INV_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> st_q[$past(inv_line)] == LS_INVALID);  // R7

    AST_KILLED_FILL_STAYS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_killed) |=> st_q[$past(fill_line)] == LS_INVALID);  // R7

endmodule

// File: rtl/cmc_miss_table.sv
module cmc_miss_table
    import cmc_pkg::*;
#(
    parameter int LINE_W  = 4,
    parameter int ENTRY_N = 4,
    parameter int TAG_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    // search by line address
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_hit,
    output logic [TAG_W-1:0]  lk_tag,
    output dir_kind_e         lk_kind,
    // allocation
    output logic [TAG_W-1:0]  free_tag,
    output logic              full,
    input  logic              alloc_en,
    input  dir_kind_e         alloc_kind,
    input  logic              alloc_killed,
    // remote invalidation
    input  logic              inv_en,
    input  logic [LINE_W-1:0] inv_line,
    // fill completion
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic [LINE_W-1:0] fill_line,
    output dir_kind_e         fill_kind,
    output logic              fill_killed
);
    logic [ENTRY_N-1:0] ent_v;
    logic [ENTRY_N-1:0] ent_kill;
    logic [LINE_W-1:0]  ent_line [ENTRY_N];
    dir_kind_e          ent_kind [ENTRY_N];
    logic [ENTRY_N-1:0] hit_vec;

    for (genvar g = 0; g < ENTRY_N; g++) begin : g_match
        assign hit_vec[g] = ent_v[g] && (ent_line[g] == lk_line);
    end

    always_comb begin
        lk_hit  = 1'b0;
        lk_tag  = '0;
        lk_kind = DR_READ;
        for (int i = 0; i < ENTRY_N; i++) begin
            if (hit_vec[i]) begin
                lk_hit  = 1'b1;
                lk_tag  = TAG_W'(i);
                lk_kind = ent_kind[i];
            end
        end
    end

    always_comb begin
        full     = 1'b1;
        free_tag = '0;
        for (int i = ENTRY_N - 1; i >= 0; i--) begin
            if (!ent_v[i]) begin
                full     = 1'b0;
                free_tag = TAG_W'(i);
            end
        end
    end

    assign fill_line   = ent_line[fill_tag];
    assign fill_kind   = ent_kind[fill_tag];
    assign fill_killed = ent_kill[fill_tag];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v    <= '0;
            ent_kill <= '0;
            for (int i = 0; i < ENTRY_N; i++) begin
                ent_line[i] <= '0;
                ent_kind[i] <= DR_READ;
            end
        end else begin
            for (int i = 0; i < ENTRY_N; i++) begin
                if (fill_en && fill_tag == TAG_W'(i)) begin
                    ent_v[i] <= 1'b0;
                end
                if (inv_en && ent_v[i] && ent_line[i] == inv_line) begin
                    ent_kill[i] <= 1'b1;
                end
                if (alloc_en && free_tag == TAG_W'(i)) begin
                    ent_v[i]    <= 1'b1;
                    ent_line[i] <= lk_line;
                    ent_kind[i] <= alloc_kind;
                    ent_kill[i] <= alloc_killed;
                end
            end
        end
    end

    AST_FILL_TARGETS_LIVE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> ent_v[fill_tag]);  // R8

    AST_ALLOC_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !full);  // R8

    AST_ONE_ENTRY_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));  // R9

    AST_NO_SECOND_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !lk_hit);  // R6

endmodule

// File: rtl/coh_miss_classifier.sv
module coh_miss_classifier
    import cmc_pkg::*;
#(
    parameter int LINE_W  = 4,
    parameter int ENTRY_N = 4,
    parameter int TAG_W   = (ENTRY_N > 1) ? $clog2(ENTRY_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LINE_W-1:0] req_line,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [2:0]        rsp_kind,
    output logic              rd_release,
    output logic              dir_req_valid,
    output logic [1:0]        dir_req_kind,
    output logic [LINE_W-1:0] dir_req_line,
    output logic [TAG_W-1:0]  dir_req_tag,
    input  logic              fill_valid,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              inv_valid,
    input  logic [LINE_W-1:0] inv_line
);
    ctl_st_e           ctl_q, ctl_d;
    logic [TAG_W-1:0]  wait_tag_q, wait_tag_d;

    line_st_e          cur_st;
    logic              lk_hit;
    logic [TAG_W-1:0]  lk_tag;
    dir_kind_e         lk_kind;
    logic [TAG_W-1:0]  free_tag;
    logic              full;
    logic [LINE_W-1:0] fill_line;
    dir_kind_e         fill_kind;
    logic              fill_killed;

    acc_kind_e         kind;
    dir_kind_e         alloc_kind;
    logic              accept;
    logic              alloc_en;
    logic              alloc_killed;
    logic              wr_to_pending;
    logic              awaited_fill;

    cmc_line_states #(.LINE_W(LINE_W)) u_states (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_line     (req_line),
        .rd_state    (cur_st),
        .fill_en     (fill_valid),
        .fill_line   (fill_line),
        .fill_kind   (fill_kind),
        .fill_killed (fill_killed),
        .inv_en      (inv_valid),
        .inv_line    (inv_line)
    );

    cmc_miss_table #(.LINE_W(LINE_W), .ENTRY_N(ENTRY_N), .TAG_W(TAG_W)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_line      (req_line),
        .lk_hit       (lk_hit),
        .lk_tag       (lk_tag),
        .lk_kind      (lk_kind),
        .free_tag     (free_tag),
        .full         (full),
        .alloc_en     (alloc_en),
        .alloc_kind   (alloc_kind),
        .alloc_killed (alloc_killed),
        .inv_en       (inv_valid),
        .inv_line     (inv_line),
        .fill_en      (fill_valid),
        .fill_tag     (fill_tag),
        .fill_line    (fill_line),
        .fill_kind    (fill_kind),
        .fill_killed  (fill_killed)
    );

    // classification of the presented access
    always_comb begin
        kind = AK_HIT;
        if (!req_write) begin
            if (lk_hit && (lk_kind != DR_UPGRADE || cur_st == LS_INVALID)) begin
                kind = AK_MERGE;
            end else if (cur_st != LS_INVALID) begin
                kind = AK_HIT;
            end else begin
                kind = AK_READ;
            end
        end else begin
            unique case (cur_st)
                LS_EXCL:   kind = AK_HIT;
                LS_SHARED: kind = AK_UPGRADE;
                default:   kind = AK_WRITE;
            endcase
        end
    end

    always_comb begin
        unique case (kind)
            AK_WRITE:   alloc_kind = DR_WRITE;
            AK_UPGRADE: alloc_kind = DR_UPGRADE;
            default:    alloc_kind = DR_READ;
        endcase
    end

    assign wr_to_pending = req_valid && req_write && lk_hit;
    assign req_ready     = (ctl_q == FS_RUN) && !fill_valid && !full && !wr_to_pending;
    assign accept        = req_valid && req_ready;
    assign alloc_en      = accept && (kind == AK_READ || kind == AK_WRITE || kind == AK_UPGRADE);
    assign alloc_killed  = inv_valid && (inv_line == req_line);
    assign awaited_fill  = fill_valid && (fill_tag == wait_tag_q);

    // next state
    always_comb begin
        ctl_d      = ctl_q;
        wait_tag_d = wait_tag_q;
        unique case (ctl_q)
            FS_RUN: begin
                if (accept && kind == AK_READ) begin
                    ctl_d      = FS_WAIT_FILL;
                    wait_tag_d = free_tag;
                end else if (accept && kind == AK_MERGE) begin
                    ctl_d      = FS_WAIT_FILL;
                    wait_tag_d = lk_tag;
                end
            end
            FS_WAIT_FILL: begin
                if (awaited_fill) begin
                    ctl_d = FS_RUN;
                end
            end
            default: ctl_d = FS_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= FS_RUN;
            wait_tag_q <= '0;
        end else begin
            ctl_q      <= ctl_d;
            wait_tag_q <= wait_tag_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_kind      <= '0;
            rd_release    <= 1'b0;
            dir_req_valid <= 1'b0;
            dir_req_kind  <= '0;
            dir_req_line  <= '0;
            dir_req_tag   <= '0;
        end else begin
            rsp_valid     <= accept;
            rsp_kind      <= kind;
            rd_release    <= (ctl_q == FS_WAIT_FILL) && awaited_fill;
            dir_req_valid <= alloc_en;
            dir_req_kind  <= alloc_kind;
            dir_req_line  <= req_line;
            dir_req_tag   <= free_tag;
        end
    end

    AST_READ_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_kind == AK_READ || rsp_kind == AK_MERGE)) |-> !req_ready);  // R2

    AST_WRITE_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_kind == AK_WRITE || rsp_kind == AK_UPGRADE)) |-> ctl_q == FS_RUN);  // R3

    AST_HIT_NO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == AK_HIT) |-> !dir_req_valid);  // R5

    AST_MERGE_NO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == AK_MERGE) |-> !dir_req_valid);  // R6

    AST_RELEASE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_release |-> $past(fill_valid));  // R6

endmodule

// File: tb/tb_coh_miss_classifier.sv
`timescale 1ns/100ps
module tb_coh_miss_classifier;
    localparam int LW = 4;
    localparam int EN = 4;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [LW-1:0] req_line = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [2:0]    rsp_kind;
    logic          rd_release;
    logic          dir_req_valid;
    logic [1:0]    dir_req_kind;
    logic [LW-1:0] dir_req_line;
    logic [TW-1:0] dir_req_tag;
    logic          fill_valid = 1'b0;
    logic [TW-1:0] fill_tag = '0;
    logic          inv_valid = 1'b0;
    logic [LW-1:0] inv_line = '0;

    always #2 clk = ~clk;

    coh_miss_classifier #(.LINE_W(LW), .ENTRY_N(EN)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_line(req_line),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rd_release(rd_release), .dir_req_valid(dir_req_valid),
        .dir_req_kind(dir_req_kind), .dir_req_line(dir_req_line),
        .dir_req_tag(dir_req_tag), .fill_valid(fill_valid), .fill_tag(fill_tag),
        .inv_valid(inv_valid), .inv_line(inv_line)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [TW-1:0] tag_of [1<<LW];

    int    q_kind [$];
    int    q_line [$];
    string q_tag  [$];

    task automatic chk(input bit ok, input string tg, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tg, act, exp);
        end
    endtask

    // monitor: compare every classification with the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_kind.size() == 0) begin
                chk(1'b0, "R1 unexpected response", int'(rsp_kind), -1);
            end else begin
                int ek, el;
                string tg;
                bit ok;
                ek = q_kind.pop_front();
                el = q_line.pop_front();
                tg = q_tag.pop_front();
                ok = (int'(rsp_kind) == ek);
                if (ek >= 1 && ek <= 3) begin
                    ok = ok && dir_req_valid && (int'(dir_req_kind) == ek - 1)
                            && (int'(dir_req_line) == el);
                end else begin
                    ok = ok && !dir_req_valid;
                end
                chk(ok, tg, int'(rsp_kind) * 10 + int'(dir_req_valid), ek * 10 + int'(ek >= 1 && ek <= 3));
            end
        end
    end

    // driver: push expectation, present access until accepted
    task automatic access(input bit wr, input int line, input int ek, input string tg);
        q_kind.push_back(ek);
        q_line.push_back(line);
        q_tag.push_back(tg);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_line  = LW'(line);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (ek >= 1 && ek <= 3) tag_of[line] = dir_req_tag;
    endtask

    task automatic fill(input int line, input bit exp_rel, input string tg);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_tag   = tag_of[line];
        @(posedge clk);
        #1;
        fill_valid = 1'b0;
        @(negedge clk);
        chk(rd_release == exp_rel, tg, int'(rd_release), int'(exp_rel));
        chk(req_ready == 1'b1 || !exp_rel, tg, int'(req_ready), 1);
    endtask

    task automatic inval(input int line);
        @(negedge clk);
        inv_valid = 1'b1;
        inv_line  = LW'(line);
        @(posedge clk);
        #1;
        inv_valid = 1'b0;
    endtask

    task automatic ready_is(input bit exp, input string tg);
        @(negedge clk);
        chk(req_ready == exp, tg, int'(req_ready), int'(exp));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0 && rd_release == 1'b0, "R1 idle outputs", int'(rsp_valid), 0);

        // R2 read miss, blocking
        access(1'b0, 1, 1, "R2 read miss");
        ready_is(1'b0, "R2 stalled on read miss");
        fill(1, 1'b1, "R2 release after fill");
        access(1'b0, 1, 0, "R5 read hit on SHARED (R2 fill)");
        // R4 upgrade, posted; R11 read hit while upgrade pending
        access(1'b1, 1, 3, "R4 upgrade miss");
        ready_is(1'b1, "R4 upgrade posted");
        access(1'b0, 1, 0, "R11 read hit during upgrade");
        fill(1, 1'b0, "R4 upgrade fill");
        access(1'b1, 1, 0, "R4 write hit on EXCLUSIVE after upgrade");

        // R3 write miss, R6 merge
        access(1'b1, 2, 2, "R3 write miss");
        ready_is(1'b1, "R3 write posted");
        access(1'b0, 2, 4, "R6 merge onto pending write");
        ready_is(1'b0, "R6 merge stalls");
        fill(2, 1'b1, "R6 release on fill");
        access(1'b1, 2, 0, "R3 write hit on EXCLUSIVE");
        access(1'b0, 2, 0, "R5 read hit on EXCLUSIVE");

        // R7 invalidation of a resident line
        inval(1);
        access(1'b0, 1, 1, "R7 read misses after invalidation");
        fill(1, 1'b1, "R7 release");

        // R7 invalidation of a pending line
        access(1'b1, 4, 2, "R7 write miss for pending test");
        inval(4);
        access(1'b0, 4, 4, "R7 merge on invalidated pending line");
        fill(4, 1'b1, "R7 killed fill still releases");
        access(1'b0, 4, 1, "R7 killed fill leaves INVALID");
        fill(4, 1'b1, "R7 refill");

        // R11 upgrade invalidated while pending
        access(1'b1, 4, 3, "R11 upgrade for kill test");
        inval(4);
        access(1'b0, 4, 4, "R11 merge after upgrade invalidated");
        fill(4, 1'b1, "R11 release");
        access(1'b1, 4, 2, "R11 write miss, line left INVALID");
        fill(4, 1'b0, "R11 write fill");

        // R8 table full
        for (int l = 5; l < 9; l++) access(1'b1, l, 2, "R8 write miss filling table");
        ready_is(1'b0, "R8 table full stalls");
        fill(5, 1'b0, "R8 entry freed");
        ready_is(1'b1, "R8 ready after entry freed");
        for (int l = 6; l < 9; l++) fill(l, 1'b0, "R8 drain");

        // R9 write to pending line held off
        access(1'b1, 9, 2, "R9 write miss");
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_line = LW'(9);
        #0.5;
        chk(req_ready == 1'b0, "R9 write to pending line held", int'(req_ready), 0);
        req_line = LW'(10);
        #0.5;
        chk(req_ready == 1'b1, "R9 other line not held", int'(req_ready), 1);
        req_valid = 1'b0;
        fill(9, 1'b0, "R9 fill");
        access(1'b1, 9, 0, "R9 write hit after fill");

        // R10 no accept during fill
        access(1'b1, 11, 2, "R10 write miss");
        @(negedge clk);
        fill_valid = 1'b1; fill_tag = tag_of[11];
        req_valid = 1'b1; req_write = 1'b0; req_line = LW'(12);
        #0.5;
        chk(req_ready == 1'b0, "R10 no accept with fill", int'(req_ready), 0);
        @(posedge clk);
        #1;
        fill_valid = 1'b0;
        req_valid  = 1'b0;
        access(1'b0, 12, 1, "R10 read miss after fill cycle");
        fill(12, 1'b1, "R10 release");

        repeat (3) @(negedge clk);
        chk(q_kind.size() == 0, "R1 all responses seen", q_kind.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule